// File: doc/BRIEF.md
# Hybrid Memory Cache Controller

This block manages a small set-associative DRAM cache placed in front of a slow non-volatile backing store. The host presents one request at a time: a read or a write, a line address, and (for writes) a whole line of data. The controller keeps the tag, valid, dirty and recency state and the line data in internal arrays. It talks to the backing store over a four-phase request/acknowledge handshake that assumes no fixed latency.

Read data never comes back after a fixed delay. When a line is ready, the controller raises a ready notification and waits for the host to grant it the bus. It drives the line in the cycle after the grant. On a read miss, the line is returned to the host before it is installed in the cache. Any dirty line displaced by that install, or by a write allocation, is written back to the backing store. A parameter set to one way turns the cache into a direct-mapped cache.

Top module: `hyb_cache_ctrl`

## Requirements
- R1: After reset, `req_ready_o` is 1, `rd_notify_o`, `rd_valid_o` and `bk_req_o` are 0, and every line is invalid, so the first access to any address is a miss.
- R2: A request is accepted in a cycle where `req_valid_i` and `req_ready_o` are both 1. From the next cycle, `req_ready_o` stays 0 until the whole request has finished, including any fetch, return, write-back and install.
- R3: A read hit raises `rd_notify_o`, makes no backing-store request, and returns the cached line.
- R4: A read miss makes exactly one backing-store read (`bk_write_o`=0) at the requested line address, then returns the line the store supplied.
- R5: `rd_notify_o` stays 1 until `bus_grant_i` is seen. `rd_valid_o` is 1 for exactly one cycle, the cycle after the grant, and `rd_data_o` carries the line in that cycle. `rd_valid_o` is never 1 at any other time.
- R6: After a read miss has been returned, the line is installed clean. A later read of it hits with no fetch, and evicting it causes no write-back.
- R7: A write carries a full line. It never reads the backing store, whether it hits or misses. It leaves the line valid and dirty in the cache.
- R8: When the line to be replaced is valid and dirty, it is written back (`bk_write_o`=1) with address {victim tag, set index} and its cached data. A clean or invalid victim is not written back.
- R9: The replacement victim in a set is the least recently used way, where a hit or an install counts as a use. From reset, the ways fill before any valid line is evicted.
- R10: Once raised, `bk_req_o` is held with stable `bk_addr_o`, `bk_write_o` and `bk_wdata_o` until `bk_ack_i` is 1. It drops in the following cycle and is not raised again until `bk_ack_i` has returned to 0.
- R11: A line address is {tag, set index}, with the set index in the low log2(SETS) bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Host request present |
| req_ready_o | output | 1 | Controller can accept a request |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | AW | Line address {tag, set index} |
| req_wdata_i | input | LW | Full-line write data |
| rd_notify_o | output | 1 | Read data ready, waiting for grant |
| bus_grant_i | input | 1 | Host grants the data bus |
| rd_valid_o | output | 1 | Read line valid on rd_data_o |
| rd_data_o | output | LW | Read line |
| bk_req_o | output | 1 | Backing-store request |
| bk_write_o | output | 1 | Backing-store request is a write-back |
| bk_addr_o | output | AW | Backing-store line address |
| bk_wdata_o | output | LW | Write-back line |
| bk_ack_i | input | 1 | Backing-store acknowledge |
| bk_rdata_i | input | LW | Backing-store read line, valid with ack |

## Verification
The bench aims at dirty-victim eviction. This includes the case where a read miss has to return its line, then write back a dirty victim, then fill. A design that installs before the write-back would lose modified data, and later reads of that address would return stale values. It also holds back the grant and varies the acknowledge latency. A controller that drives data before the grant, or drops its request early, gives a wrong or early `rd_valid_o` or breaks the handshake. Directed sequences check the LRU order after a hit, and that clean filled lines vanish silently. A design that marks fills dirty would produce a spurious write-back.

// File: rtl/hyb_pkg.sv
package hyb_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_LOOKUP, ST_FETCH, ST_FETCH_REL, ST_NOTIFY,
    ST_RETURN, ST_WB, ST_WB_REL, ST_INSTALL
  } hyb_state_e;
endpackage

// File: rtl/hyb_tag_store.sv
module hyb_tag_store #(
  parameter int SETS = 16,
  parameter int WAYS = 4,
  parameter int TW   = 12,
  localparam int IW  = $clog2(SETS),
  localparam int WW  = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [IW-1:0] set_i,
  input  logic [TW-1:0] lk_tag_i,
  output logic          hit_o,
  output logic [WW-1:0] hit_way_o,
  input  logic [WW-1:0] rd_way_i,
  output logic          rd_valid_o,
  output logic          rd_dirty_o,
  output logic [TW-1:0] rd_tag_o,
  input  logic          wr_en_i,
  input  logic [WW-1:0] wr_way_i,
  input  logic [TW-1:0] wr_tag_i,
  input  logic          wr_dirty_i
);
  logic [TW-1:0] tag_q   [SETS][WAYS];
  logic          valid_q [SETS][WAYS];
  logic          dirty_q [SETS][WAYS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < SETS; s++)
        for (int w = 0; w < WAYS; w++) begin
          valid_q[s][w] <= 1'b0;
          dirty_q[s][w] <= 1'b0;
        end
    end else if (wr_en_i) begin
      valid_q[set_i][wr_way_i] <= 1'b1;
      dirty_q[set_i][wr_way_i] <= wr_dirty_i;
    end
  end

  always_ff @(posedge clk_i) begin
    if (wr_en_i) tag_q[set_i][wr_way_i] <= wr_tag_i;
  end

  always_comb begin
    hit_o     = 1'b0;
    hit_way_o = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (valid_q[set_i][w] && tag_q[set_i][w] == lk_tag_i) begin
        hit_o     = 1'b1;
        hit_way_o = WW'(w);
      end
    end
  end

  assign rd_valid_o = valid_q[set_i][rd_way_i];
  assign rd_dirty_o = dirty_q[set_i][rd_way_i];
  assign rd_tag_o   = tag_q[set_i][rd_way_i];
endmodule

// File: rtl/hyb_lru.sv
module hyb_lru #(
  parameter int SETS = 16,
  parameter int WAYS = 4,
  localparam int IW  = $clog2(SETS),
  localparam int WW  = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [IW-1:0] set_i,
  input  logic          touch_i,
  input  logic [WW-1:0] touch_way_i,
  output logic [WW-1:0] victim_o
);
  if (WAYS == 1) begin : g_direct
    assign victim_o = '0;
  end else begin : g_assoc
    // per-way age, 0 = most recent, WAYS-1 = victim
    logic [WW-1:0] age_q [SETS][WAYS];
    logic [WW-1:0] old_age;

    assign old_age = age_q[set_i][touch_way_i];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        for (int s = 0; s < SETS; s++)
          for (int w = 0; w < WAYS; w++)
            age_q[s][w] <= WW'(w);
      end else if (touch_i) begin
        for (int w = 0; w < WAYS; w++) begin
          if (WW'(w) == touch_way_i)         age_q[set_i][w] <= '0;
          else if (age_q[set_i][w] < old_age) age_q[set_i][w] <= age_q[set_i][w] + 1'b1;
        end
      end
    end

    always_comb begin
      victim_o = '0;
      for (int w = 0; w < WAYS; w++)
        if (age_q[set_i][w] == WW'(WAYS - 1)) victim_o = WW'(w);
    end
  end
endmodule

// File: rtl/hyb_data_store.sv
module hyb_data_store #(
  parameter int SETS = 16,
  parameter int WAYS = 4,
  parameter int LW   = 64,
  localparam int IW  = $clog2(SETS),
  localparam int WW  = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic          clk_i,
  input  logic [IW-1:0] set_i,
  input  logic [WW-1:0] rd_way_i,
  output logic [LW-1:0] rd_data_o,
  input  logic          wr_en_i,
  input  logic [WW-1:0] wr_way_i,
  input  logic [LW-1:0] wr_data_i
);
  logic [LW-1:0] line_q [SETS][WAYS];

  always_ff @(posedge clk_i) begin
    if (wr_en_i) line_q[set_i][wr_way_i] <= wr_data_i;
  end

  assign rd_data_o = line_q[set_i][rd_way_i];
endmodule

// File: rtl/hyb_cache_ctrl.sv
module hyb_cache_ctrl
  import hyb_pkg::*;
#(
  parameter int SETS = 16,
  parameter int WAYS = 4,
  parameter int LW   = 64,
  parameter int AW   = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_valid_i,
  output logic          req_ready_o,
  input  logic          req_write_i,
  input  logic [AW-1:0] req_addr_i,
  input  logic [LW-1:0] req_wdata_i,
  output logic          rd_notify_o,
  input  logic          bus_grant_i,
  output logic          rd_valid_o,
  output logic [LW-1:0] rd_data_o,
  output logic          bk_req_o,
  output logic          bk_write_o,
  output logic [AW-1:0] bk_addr_o,
  output logic [LW-1:0] bk_wdata_o,
  input  logic          bk_ack_i,
  input  logic [LW-1:0] bk_rdata_i
);
  localparam int IW = $clog2(SETS);
  localparam int TW = AW - IW;
  localparam int WW = (WAYS > 1) ? $clog2(WAYS) : 1;

  hyb_state_e    state_q;
  logic          is_wr_q, hit_q, vdirty_q;
  logic [AW-1:0] addr_q;
  logic [LW-1:0] wdata_q, line_q;
  logic [WW-1:0] way_q;
  logic [TW-1:0] vtag_q;

  logic [IW-1:0] set_idx;
  logic [TW-1:0] tag_idx;
  logic          hit, v_valid, v_dirty, install, touch;
  logic [WW-1:0] hit_way, victim, dat_way;
  logic [TW-1:0] v_tag;
  logic [LW-1:0] dat_rd;

  assign set_idx = addr_q[IW-1:0];
  assign tag_idx = addr_q[AW-1:IW];
  assign install = (state_q == ST_INSTALL);
  assign touch   = install || (state_q == ST_RETURN && hit_q);
  assign dat_way = (state_q == ST_LOOKUP) ? hit_way : way_q;

  hyb_tag_store #(.SETS(SETS), .WAYS(WAYS), .TW(TW)) u_tags (
    .clk_i, .rst_ni,
    .set_i      (set_idx),
    .lk_tag_i   (tag_idx),
    .hit_o      (hit),
    .hit_way_o  (hit_way),
    .rd_way_i   (victim),
    .rd_valid_o (v_valid),
    .rd_dirty_o (v_dirty),
    .rd_tag_o   (v_tag),
    .wr_en_i    (install),
    .wr_way_i   (way_q),
    .wr_tag_i   (tag_idx),
    .wr_dirty_i (is_wr_q)
  );

  hyb_lru #(.SETS(SETS), .WAYS(WAYS)) u_lru (
    .clk_i, .rst_ni,
    .set_i       (set_idx),
    .touch_i     (touch),
    .touch_way_i (way_q),
    .victim_o    (victim)
  );

  hyb_data_store #(.SETS(SETS), .WAYS(WAYS), .LW(LW)) u_data (
    .clk_i,
    .set_i     (set_idx),
    .rd_way_i  (dat_way),
    .rd_data_o (dat_rd),
    .wr_en_i   (install),
    .wr_way_i  (way_q),
    .wr_data_i (is_wr_q ? wdata_q : line_q)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      is_wr_q  <= 1'b0;
      hit_q    <= 1'b0;
      vdirty_q <= 1'b0;
      addr_q   <= '0;
      wdata_q  <= '0;
      line_q   <= '0;
      way_q    <= '0;
      vtag_q   <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (req_valid_i) begin
          is_wr_q <= req_write_i;
          addr_q  <= req_addr_i;
          wdata_q <= req_wdata_i;
          state_q <= ST_LOOKUP;
        end
        ST_LOOKUP: begin
          hit_q    <= hit;
          way_q    <= hit ? hit_way : victim;
          vdirty_q <= !hit && v_valid && v_dirty;
          vtag_q   <= v_tag;
          if (is_wr_q)  state_q <= (!hit && v_valid && v_dirty) ? ST_WB : ST_INSTALL;
          else if (hit) begin
            line_q  <= dat_rd;
            state_q <= ST_NOTIFY;
          end else state_q <= ST_FETCH;
        end
        ST_FETCH: if (bk_ack_i) begin
          line_q  <= bk_rdata_i;
          state_q <= ST_FETCH_REL;
        end
        ST_FETCH_REL: if (!bk_ack_i) state_q <= ST_NOTIFY;
        ST_NOTIFY:    if (bus_grant_i) state_q <= ST_RETURN;
        ST_RETURN: begin
          if (hit_q)         state_q <= ST_IDLE;
          else if (vdirty_q) state_q <= ST_WB;
          else               state_q <= ST_INSTALL;
        end
        ST_WB:      if (bk_ack_i)  state_q <= ST_WB_REL;
        ST_WB_REL:  if (!bk_ack_i) state_q <= ST_INSTALL;
        ST_INSTALL: state_q <= ST_IDLE;
        default:    state_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready_o = (state_q == ST_IDLE);
  assign rd_notify_o = (state_q == ST_NOTIFY);
  assign rd_valid_o  = (state_q == ST_RETURN);
  assign rd_data_o   = rd_valid_o ? line_q : '0;
  assign bk_req_o    = (state_q == ST_FETCH) || (state_q == ST_WB);
  assign bk_write_o  = (state_q == ST_WB) || (state_q == ST_WB_REL);
  assign bk_addr_o   = bk_write_o ? {vtag_q, set_idx} : addr_q;
  assign bk_wdata_o  = bk_write_o ? dat_rd : '0;
endmodule

// File: rtl/hyb_cache_ctrl_chk.sv
module hyb_cache_ctrl_chk #(
  parameter int LW = 64,
  parameter int AW = 16
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          req_valid_i,
  input logic          req_ready_o,
  input logic          rd_notify_o,
  input logic          bus_grant_i,
  input logic          rd_valid_o,
  input logic          bk_req_o,
  input logic          bk_write_o,
  input logic [AW-1:0] bk_addr_o,
  input logic [LW-1:0] bk_wdata_o,
  input logic          bk_ack_i
);
  a_r2_busy_after_accept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && req_ready_o |=> !req_ready_o);

  a_r2_exclusive_phase: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({req_ready_o, rd_notify_o, rd_valid_o, bk_req_o}));

  a_r5_notify_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_notify_o && !bus_grant_i |=> rd_notify_o);

  a_r5_data_after_grant: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o |-> $past(rd_notify_o) && $past(bus_grant_i));

  a_r5_single_beat: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o |=> !rd_valid_o);

  a_r10_req_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bk_req_o && !bk_ack_i |=> bk_req_o && $stable(bk_addr_o) && $stable(bk_write_o)
                              && $stable(bk_wdata_o));

  a_r10_req_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bk_req_o && bk_ack_i |=> !bk_req_o);

  a_r10_ack_idle_on_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(bk_req_o) |-> !bk_ack_i);
endmodule

bind hyb_cache_ctrl hyb_cache_ctrl_chk #(.LW(LW), .AW(AW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_i (req_valid_i),
  .req_ready_o (req_ready_o),
  .rd_notify_o (rd_notify_o),
  .bus_grant_i (bus_grant_i),
  .rd_valid_o  (rd_valid_o),
  .bk_req_o    (bk_req_o),
  .bk_write_o  (bk_write_o),
  .bk_addr_o   (bk_addr_o),
  .bk_wdata_o  (bk_wdata_o),
  .bk_ack_i    (bk_ack_i)
);

// File: tb/hyb_cache_ctrl_test.sv
module hyb_cache_ctrl_test;
  localparam int SETS = 16, WAYS = 4, LW = 64, AW = 16;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic req_valid_i = 1'b0, req_write_i = 1'b0, bus_grant_i = 1'b0, bk_ack_i = 1'b0;
  logic [AW-1:0] req_addr_i = '0;
  logic [LW-1:0] req_wdata_i = '0, bk_rdata_i = '0;
  logic req_ready_o, rd_notify_o, rd_valid_o, bk_req_o, bk_write_o;
  logic [LW-1:0] rd_data_o, bk_wdata_o;
  logic [AW-1:0] bk_addr_o;

  always #2ns clk_i = ~clk_i;

  hyb_cache_ctrl #(.SETS(SETS), .WAYS(WAYS), .LW(LW), .AW(AW)) uut (.*);

  int checks = 0, fails = 0;
  int rd_cnt = 0, hs_err = 0;
  logic [AW-1:0] rd_addr_last;
  logic [AW-1:0] wb_a[$];
  logic [LW-1:0] wb_d[$];
  logic [LW-1:0] bmem[logic [AW-1:0]];

  // cache model
  logic [11:0] m_tag  [SETS][WAYS];
  bit          m_val  [SETS][WAYS];
  bit          m_dty  [SETS][WAYS];
  logic [LW-1:0] m_dat[SETS][WAYS];
  int          m_age  [SETS][WAYS];

  task automatic check(input bit ok, input string req, input string what,
                       input logic [LW-1:0] act, input logic [LW-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [LW-1:0] init_line(input logic [AW-1:0] a);
    return {a, a ^ 16'h5a5a, ~a, a + 16'h1234};
  endfunction

  function automatic logic [LW-1:0] mem_rd(input logic [AW-1:0] a);
    if (bmem.exists(a)) return bmem[a];
    return init_line(a);
  endfunction

  function automatic void m_touch(input int s, input int w);
    int old = m_age[s][w];
    for (int k = 0; k < WAYS; k++) begin
      if (k == w) m_age[s][k] = 0;
      else if (m_age[s][k] < old) m_age[s][k]++;
    end
  endfunction

  function automatic int m_victim(input int s);
    for (int k = 0; k < WAYS; k++) if (m_age[s][k] == WAYS - 1) return k;
    return 0;
  endfunction

  // backing store responder, four-phase
  initial begin
    forever begin
      @(negedge clk_i);
      if (bk_req_o && !bk_ack_i) begin
        int lat;
        logic [AW-1:0] ha;
        logic [LW-1:0] hd;
        bit hw;
        lat = $urandom_range(0, 4);
        ha = bk_addr_o; hw = bk_write_o; hd = bk_wdata_o;
        repeat (lat) begin
          @(negedge clk_i);
          if (!bk_req_o || bk_addr_o != ha || bk_write_o != hw || (hw && bk_wdata_o != hd))
            hs_err++;
        end
        if (hw) begin
          wb_a.push_back(ha); wb_d.push_back(hd); bmem[ha] = hd;
        end else begin
          rd_cnt++; rd_addr_last = ha; bk_rdata_i = mem_rd(ha);
        end
        bk_ack_i = 1'b1;
        do @(negedge clk_i); while (bk_req_o);
        repeat ($urandom_range(0, 3)) @(negedge clk_i);
        bk_ack_i = 1'b0;
      end
    end
  end

  task automatic do_access(input bit wr, input logic [AW-1:0] a, input logic [LW-1:0] wd,
                           output int n_fetch, output int n_wb, output logic [AW-1:0] wb_addr);
    int s, h, v, waits;
    logic [11:0] t;
    logic [LW-1:0] exp_d;
    bit exp_wb;
    logic [AW-1:0] exp_wa;
    logic [LW-1:0] exp_wd;
    s = int'(a[3:0]); t = a[15:4]; h = -1; exp_wb = 0; exp_wa = '0; exp_wd = '0;
    for (int k = 0; k < WAYS; k++) if (m_val[s][k] && m_tag[s][k] == t) h = k;
    if (h >= 0) begin
      exp_d = m_dat[s][h];
      if (wr) begin m_dat[s][h] = wd; m_dty[s][h] = 1; end
      m_touch(s, h);
    end else begin
      v = m_victim(s);
      if (m_val[s][v] && m_dty[s][v]) begin
        exp_wb = 1; exp_wa = {m_tag[s][v], a[3:0]}; exp_wd = m_dat[s][v];
      end
      exp_d = mem_rd(a);
      m_val[s][v] = 1; m_tag[s][v] = t; m_dty[s][v] = wr;
      m_dat[s][v] = wr ? wd : exp_d;
      m_touch(s, v);
    end
    rd_cnt = 0; wb_a.delete(); wb_d.delete();

    while (!req_ready_o) @(negedge clk_i);
    req_valid_i = 1; req_write_i = wr; req_addr_i = a; req_wdata_i = wd;
    @(negedge clk_i);
    req_valid_i = 0;
    check(!req_ready_o, "R2", "ready after accept", LW'(req_ready_o), 0);
    if (!wr) begin
      waits = 0;
      while (!rd_notify_o) begin
        if (rd_valid_o) check(0, "R5", "rd_valid before notify", 1, 0);
        @(negedge clk_i);
      end
      repeat ($urandom_range(0, 3)) begin
        @(negedge clk_i);
        waits++;
        check(rd_notify_o && !rd_valid_o, "R5", "notify held, no data w/o grant",
              LW'({rd_notify_o, rd_valid_o}), LW'(2'b10));
      end
      bus_grant_i = 1;
      @(negedge clk_i);
      bus_grant_i = 0;
      check(rd_valid_o, "R5", "rd_valid after grant", LW'(rd_valid_o), 1);
      check(rd_data_o == exp_d, (h >= 0) ? "R3" : "R4", "read data", rd_data_o, exp_d);
      @(negedge clk_i);
      check(!rd_valid_o, "R5", "rd_valid one cycle", LW'(rd_valid_o), 0);
    end
    while (!req_ready_o) @(negedge clk_i);
    n_fetch = rd_cnt; n_wb = wb_a.size(); wb_addr = (n_wb > 0) ? wb_a[0] : '0;
    if (wr)           check(rd_cnt == 0, "R7", "fetch count on write", LW'(rd_cnt), 0);
    else if (h >= 0)  check(rd_cnt == 0, "R3", "fetch count on hit", LW'(rd_cnt), 0);
    else begin
      check(rd_cnt == 1, "R4", "fetch count on miss", LW'(rd_cnt), 1);
      check(rd_addr_last == a, "R4", "fetch address", LW'(rd_addr_last), LW'(a));
    end
    check(n_wb == int'(exp_wb), "R8", "write-back count", LW'(n_wb), LW'(exp_wb));
    if (exp_wb && n_wb == 1) begin
      check(wb_a[0] == exp_wa, "R8", "write-back address", LW'(wb_a[0]), LW'(exp_wa));
      check(wb_d[0] == exp_wd, "R8", "write-back data", wb_d[0], exp_wd);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    fails++;
    $display("FAIL R2 watchdog actual=hung expected=complete");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int nf, nw;
    logic [AW-1:0] wa;
    void'($urandom(32'd1234));
    for (int s = 0; s < SETS; s++)
      for (int w = 0; w < WAYS; w++) begin
        m_val[s][w] = 0; m_dty[s][w] = 0; m_age[s][w] = w; m_tag[s][w] = '0; m_dat[s][w] = '0;
      end
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i);
    // R1 reset state
    check(req_ready_o, "R1", "ready after reset", LW'(req_ready_o), 1);
    check(!rd_notify_o && !rd_valid_o && !bk_req_o, "R1", "outputs idle after reset",
          LW'({rd_notify_o, rd_valid_o, bk_req_o}), 0);
    do_access(0, {12'h100, 4'd9}, '0, nf, nw, wa);
    check(nf == 1, "R1", "first access misses", LW'(nf), 1);

    // R6 clean fill: hits later, evicts silently
    do_access(0, {12'h020, 4'd7}, '0, nf, nw, wa);
    do_access(0, {12'h020, 4'd7}, '0, nf, nw, wa);
    check(nf == 0, "R6", "filled line hits", LW'(nf), 0);
    for (int k = 1; k <= 4; k++) do_access(0, {12'h020 + 12'(k), 4'd7}, '0, nf, nw, wa);
    check(nw == 0, "R6", "clean eviction no write-back", LW'(nw), 0);

    // R9 LRU after hit, R11 address layout
    for (int k = 1; k <= 4; k++) do_access(1, {12'(k), 4'd5}, {32'hcafe0000, 32'(k)}, nf, nw, wa);
    check(nw == 0, "R9", "ways fill before eviction", LW'(nw), 0);
    do_access(0, {12'd1, 4'd5}, '0, nf, nw, wa);
    do_access(1, {12'd5, 4'd5}, 64'h5555, nf, nw, wa);
    check(nw == 1 && wa == {12'd2, 4'd5}, "R9", "LRU victim is tag 2", LW'(wa), LW'({12'd2, 4'd5}));
    check(wa[3:0] == 4'd5, "R11", "set index in low bits", LW'(wa[3:0]), 5);

    // R8 dirty victim on read miss
    do_access(0, {12'd6, 4'd5}, '0, nf, nw, wa);
    check(nw == 1 && wa == {12'd3, 4'd5}, "R8", "read miss writes back dirty victim",
          LW'(wa), LW'({12'd3, 4'd5}));
    do_access(0, {12'd2, 4'd5}, '0, nf, nw, wa);

    // random mix
    for (int i = 0; i < 600; i++) begin
      bit wr = 1'($urandom_range(0, 1));
      logic [AW-1:0] a = {12'($urandom_range(0, 5)), 4'($urandom_range(0, 2))};
      do_access(wr, a, {$urandom, $urandom}, nf, nw, wa);
    end
    check(hs_err == 0, "R10", "request stable until ack", LW'(hs_err), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule